// File: doc/BRIEF.md
# Physical Address Special-Region Classifier

This block sits just after address translation. Each cycle it takes one translated 32-bit physical address and decides whether the access goes to one of two special windows. It then registers the decision, together with a rewritten address, for the next pipeline stage.

The first window is fixed at the top 64 KiB of the 32-bit space. It carries pseudo-instruction register traffic. Such an access is tagged with two register-access flags, and its address is rebuilt from its two low byte fields.

The second window is a single 4 KiB page whose page number software programs. It is the local interrupt controller page. It is honoured only in full-system mode. An access there is tagged uncacheable and moved into a window private to the issuing context.

Every other address passes through unchanged with no flags.

Top module: `phys_addr_classifier`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, `out_valid`, `out_mmreg`, `out_generic` and `out_uncached` are 0 and `out_addr` is 0.
- R2: The stage has exactly one cycle of latency: `out_valid` equals `in_valid` of the previous cycle. When the previous cycle had `in_valid` low, all flags and `out_addr` are 0.
- R3: An address in 0xFFFF0000..0xFFFFFFFF inclusive sets both `out_mmreg` and `out_generic` and clears `out_uncached`. 0xFFFEFFFF is outside this window.
- R4: For a pseudo-instruction window hit, `out_addr` = `PSEUDO_OUT_BASE` OR (address bits 15:8 shifted left by 8) OR address bits 7:0. Bits 15:8 are the function code and bits 7:0 the sub-function. The default base is 0x8_0000_0000.
- R5: With `full_sys_en` high, an address from `ctl_base_page`×4096 through `ctl_base_page`×4096+4095 inclusive sets `out_uncached` and clears `out_mmreg` and `out_generic`. The page size is 4096 bytes.
- R6: For an interrupt window hit, `out_addr` = `CTX_WIN_BASE` + `ctx_id`×4096 + (address − `ctl_base_page`×4096). The default `CTX_WIN_BASE` is 0x4_0000_0000.
- R7: When both windows contain the address, the pseudo-instruction window wins and R3 and R4 apply.
- R8: With `full_sys_en` low, the interrupt window is not recognised. Such an address passes through zero-extended with all flags 0.
- R9: Any address in neither window passes through zero-extended into `out_addr` with all flags 0.
- R10: Interrupt window hits are rebased whatever their alignment. An odd, unaligned offset is carried into `out_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Address on `in_addr` is valid this cycle |
| in_addr | input | 32 | Translated physical address |
| ctl_base_page | input | 20 | Page number of the interrupt controller page |
| full_sys_en | input | 1 | Enables recognition of the interrupt controller page |
| ctx_id | input | CTX_W (8) | Context issuing the access |
| out_valid | output | 1 | Registered result valid |
| out_addr | output | OUT_W (36) | Rewritten physical address |
| out_mmreg | output | 1 | Memory-mapped register access |
| out_generic | output | 1 | Generic (pseudo-instruction) register access |
| out_uncached | output | 1 | Access must bypass caches |

## Verification
The bench probes the edges of both windows, such as 0xFFFEFFFF against 0xFFFF0000 and the bytes just before, at the start of, at the end of and just past the programmed page. A design with an off-by-one window compare would flag or leave unflagged one of these addresses.

It programs the interrupt page inside the top 64 KiB. A design that checks the windows in the wrong order would then report an uncacheable access instead of a register access.

It drops `full_sys_en` while hitting the page, which catches a design that ignores the mode. It also varies the context ID with an odd offset, which catches a rebase that drops the context stride or masks alignment bits.

// File: rtl/phys_addr_classifier.sv
module phys_addr_classifier #(
  parameter int CTX_W     = 8,
  parameter int OUT_W     = 36,
  parameter int PAGE_BITS = 12,
  parameter logic [OUT_W-1:0] PSEUDO_OUT_BASE = 36'h8_0000_0000,
  parameter logic [OUT_W-1:0] CTX_WIN_BASE    = 36'h4_0000_0000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [31:0]                 in_addr,
  input  logic [31-PAGE_BITS:0]       ctl_base_page,
  input  logic                        full_sys_en,
  input  logic [CTX_W-1:0]            ctx_id,
  output logic                        out_valid,
  output logic [OUT_W-1:0]            out_addr,
  output logic                        out_mmreg,
  output logic                        out_generic,
  output logic                        out_uncached
);
  localparam int ADDR_W = 32;

  logic pseudo_hit, ctl_hit;
  logic [OUT_W-1:0] pseudo_addr, ctx_addr, next_addr;

  assign pseudo_hit  = in_addr[ADDR_W-1:16] == 16'hFFFF;
  assign ctl_hit     = full_sys_en && !pseudo_hit &&
                       (in_addr[ADDR_W-1:PAGE_BITS] == ctl_base_page);
  assign pseudo_addr = PSEUDO_OUT_BASE | OUT_W'({in_addr[15:8], in_addr[7:0]});
  assign ctx_addr    = CTX_WIN_BASE + (OUT_W'(ctx_id) << PAGE_BITS)
                     + OUT_W'(in_addr[PAGE_BITS-1:0]);
  assign next_addr   = pseudo_hit ? pseudo_addr :
                       ctl_hit    ? ctx_addr    : OUT_W'(in_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_addr     <= '0;
      out_mmreg    <= 1'b0;
      out_generic  <= 1'b0;
      out_uncached <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      out_addr     <= in_valid ? next_addr : '0;
      out_mmreg    <= in_valid && pseudo_hit;
      out_generic  <= in_valid && pseudo_hit;
      out_uncached <= in_valid && ctl_hit;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R3
  pseudo_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_addr >= 32'hFFFF_0000) |=> (out_mmreg && out_generic && !out_uncached));

  // R5
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_uncached |-> (!out_mmreg && !out_generic));

  // R4
  pseudo_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_mmreg |-> ((out_addr & ~OUT_W'(32'h0000_FFFF)) == PSEUDO_OUT_BASE));

  // R8
  nofs_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !full_sys_en && in_addr < 32'hFFFF_0000)
      |=> (!out_uncached && out_addr == OUT_W'($past(in_addr))));

  // R1
  reset_chk: assert property (@(posedge clk)
    !$past(rst_n) |-> (!out_valid && !out_mmreg && !out_uncached));
endmodule

// File: tb/tb_phys_addr_classifier.sv
module tb_phys_addr_classifier;
  localparam int CTX_W = 8;
  localparam int OUT_W = 36;
  localparam logic [OUT_W-1:0] PBASE = 36'h8_0000_0000;
  localparam logic [OUT_W-1:0] CBASE = 36'h4_0000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_addr = '0;
  logic [19:0] ctl_base_page = '0;
  logic full_sys_en = 1'b0;
  logic [CTX_W-1:0] ctx_id = '0;
  logic out_valid, out_mmreg, out_generic, out_uncached;
  logic [OUT_W-1:0] out_addr;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  phys_addr_classifier dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .ctl_base_page(ctl_base_page), .full_sys_en(full_sys_en), .ctx_id(ctx_id),
    .out_valid(out_valid), .out_addr(out_addr), .out_mmreg(out_mmreg),
    .out_generic(out_generic), .out_uncached(out_uncached));

  task automatic check(string req, logic [OUT_W+3:0] act, logic [OUT_W+3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [31:0] a, logic [19:0] bp, logic fs, logic [CTX_W-1:0] c,
                      string req, logic [OUT_W-1:0] ea, logic emm, logic eunc);
    @(negedge clk);
    in_addr = a; ctl_base_page = bp; full_sys_en = fs; ctx_id = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {out_valid, out_mmreg, out_generic, out_uncached, out_addr},
          {1'b1, emm, emm, eunc, ea});
  endtask

  task automatic t_reset();
    check("R1", {out_valid, out_mmreg, out_generic, out_uncached, out_addr}, '0);
  endtask

  task automatic t_pseudo();
    send(32'hFFFF_0000, 20'h00001, 1'b1, 8'd3, "R3", PBASE, 1'b1, 1'b0);
    send(32'hFFFF_FFFF, 20'h00001, 1'b0, 8'd3, "R3", PBASE | 36'hFFFF, 1'b1, 1'b0);
    send(32'hFFFF_A55A, 20'h00001, 1'b1, 8'd0, "R4", PBASE | 36'hA55A, 1'b1, 1'b0);
    send(32'hFFFE_FFFF, 20'h00001, 1'b1, 8'd0, "R3", 36'hFFFE_FFFF, 1'b0, 1'b0);
  endtask

  task automatic t_ctl();
    send(32'hFEE0_0000, 20'hFEE00, 1'b1, 8'd0, "R5", CBASE, 1'b0, 1'b1);
    send(32'hFEE0_0FFF, 20'hFEE00, 1'b1, 8'd2, "R6", CBASE + 36'h2000 + 36'hFFF, 1'b0, 1'b1);
    send(32'hFEDF_FFFF, 20'hFEE00, 1'b1, 8'd2, "R5", 36'hFEDF_FFFF, 1'b0, 1'b0);
    send(32'hFEE0_1000, 20'hFEE00, 1'b1, 8'd2, "R5", 36'hFEE0_1000, 1'b0, 1'b0);
    send(32'hFEE0_0123, 20'hFEE00, 1'b1, 8'd255, "R10", CBASE + 36'hFF000 + 36'h123, 1'b0, 1'b1);
  endtask

  task automatic t_prio_mode();
    send(32'hFFFF_F010, 20'hFFFFF, 1'b1, 8'd5, "R7", PBASE | 36'hF010, 1'b1, 1'b0);
    send(32'hFEE0_0040, 20'hFEE00, 1'b0, 8'd1, "R8", 36'hFEE0_0040, 1'b0, 1'b0);
    send(32'h1234_5678, 20'hFEE00, 1'b1, 8'd1, "R9", 36'h1234_5678, 1'b0, 1'b0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    check("R2", {out_valid, out_mmreg, out_generic, out_uncached, out_addr}, '0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pseudo();
        t_ctl();
        t_prio_mode();
        t_idle();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule